// File: doc/BRIEF.md
# Calibration Register Copy Sequencer

This block loads a set of calibration values from a nonvolatile memory into a target register file after boot. One start strobe begins the run. The block first checks the stored block. In tag mode it reads only the check word and compares it with a fixed tag. In digest mode it reads every stored value, XOR-folds them, and compares the result with the check word. If the check passes, the block reads each value again and writes it to the target register of the same index. The writes go in strictly ascending order, and each one waits for the target's ready. When the last write is accepted, the block raises a sticky init-done flag.

A monitor plays the part of a host polling for init-done. It starts counting at the accepted start. If done has not appeared within a bound of about 100 us, derived from the clock frequency, it raises a sticky timeout flag. A lifecycle input makes the copy mandatory. When that input is low, a second input decides whether the copy runs at all. Only one run is accepted per reset.

Top module: `cal_copy_seq`

## Requirements
- R1: Target writes carry the addresses 0, 1, ..., NUM_REGS-1 exactly once each, in that order, with no gap and no repeat.
- R2: The data written to target register i equals the memory word at address i. Memory addresses 0..NUM_REGS-1 hold the values, and address NUM_REGS holds the check word.
- R3: A write request keeps its valid, address and data unchanged until the cycle in which ready is high. The index advances only on that handshake, so stalls on ready cost cycles but never lose or repeat a write.
- R4: init_done_o rises only in the cycle after the handshake of the write to address NUM_REGS-1. It then stays high until reset.
- R5: With chk_mode_i=0 (tag mode), the copy runs only when the check word equals the parameter TAG (default 16'hC0DE). On a mismatch there are no target writes and init_done_o stays low.
- R6: With chk_mode_i=1 (digest mode), the copy runs only when the check word equals the XOR of memory words 0..NUM_REGS-1. On a mismatch there are no target writes and init_done_o stays low.
- R7: With lc_mandatory_i=1 the copy runs whatever copy_en_i is. With both inputs low, an accepted start issues no memory reads and no writes, and done stays low.
- R8: timeout_o rises exactly TIMEOUT_CYC clock edges after the edge that accepted start, if init_done_o has not risen by then. TIMEOUT_CYC defaults to 100 us at CLK_HZ, which is 5000 cycles at 50 MHz. It then stays high until reset. If done comes first, it never rises.
- R9: A start strobe is ignored while a run is in progress and after a run has ended. Only the first start after reset has any effect.
- R10: After reset, mem_req_o, wr_valid_o, init_done_o and timeout_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe |
| lc_mandatory_i | input | 1 | Lifecycle mode in which the copy is mandatory |
| copy_en_i | input | 1 | Copy select when not mandatory |
| chk_mode_i | input | 1 | 0 = tag check, 1 = digest check (sampled at start) |
| mem_req_o | output | 1 | Memory read request, held until mem_rvalid_i |
| mem_addr_o | output | IDX_W | Memory read address |
| mem_rdata_i | input | DATA_W | Memory read data |
| mem_rvalid_i | input | 1 | Memory read data valid |
| wr_valid_o | output | 1 | Target write valid |
| wr_ready_i | input | 1 | Target write ready |
| wr_addr_o | output | REG_AW | Target register index |
| wr_data_o | output | DATA_W | Target write data |
| init_done_o | output | 1 | Sticky: all registers written |
| timeout_o | output | 1 | Sticky: done did not appear within the bound |

## Verification
The bench logs every write handshake while the target stalls ready on an irregular pattern. A design that advanced its index on valid alone, or dropped a beat during a stall, would show a gap or a repeated address in the log, or the wrong data. Both check modes are run with a corrupted check word; a design that wrote even one register before deciding would leave entries in the write log. The timeout edge is sampled in the exact cycle before and the exact cycle of its expected rise, so an off-by-one in the limit shows up. Extra start strobes during and after a run must leave the log untouched, and the skip case must issue no memory reads.

// File: rtl/cal_copy_pkg.sv
// Package: shared state encoding for the calibration copy sequencer.
// Assumes: nothing; types only.
package cal_copy_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // waiting for the one start of this reset period
        ST_VRD   = 3'd1,  // reading words for the gating check
        ST_VCMP  = 3'd2,  // comparing check word against tag or digest
        ST_CRD   = 3'd3,  // reading one word for the copy
        ST_CWR   = 3'd4,  // offering one word to the target
        ST_DONE  = 3'd5,  // copy complete, terminal
        ST_HALT  = 3'd6   // check failed or copy skipped, terminal
    } seq_state_e;

endpackage

// File: rtl/cal_check_unit.sv
// Module: gating check unit. Folds the stored values by XOR and holds the
// check word. It reports a pass either against the fixed tag or against the
// fold, depending on the mode.
// Assumes: the controller clears the fold before a run and loads the check
// word before it looks at pass_o.
module cal_check_unit #(
    parameter int          DATA_W = 16,
    parameter logic [15:0] TAG    = 16'hC0DE
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              acc_en_i,
    input  logic              load_i,
    input  logic              mode_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              pass_o
);

    localparam logic [DATA_W-1:0] TAG_W = DATA_W'(TAG);

    logic [DATA_W-1:0] fold_q;
    logic [DATA_W-1:0] chk_q;

    // Accumulate the XOR fold of the stored values.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || clr_i) begin
            fold_q <= '0;
        end else if (acc_en_i) begin
            fold_q <= fold_q ^ data_i;
        end
    end

    // Capture the stored check word.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || clr_i) begin
            chk_q <= '0;
        end else if (load_i) begin
            chk_q <= data_i;
        end
    end

    // Compare the check word with the fold (digest) or with the tag.
    always_comb begin
        if (mode_i) begin
            pass_o = (chk_q == fold_q);
        end else begin
            pass_o = (chk_q == TAG_W);
        end
    end

    // R5: in tag mode the fold is never used, so it never accumulates.
    a_r5_tag_no_fold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mode_i && acc_en_i) |-> 1'b0 == (acc_en_i && !mode_i))
        else $error("fold accumulated in tag mode");

endmodule

// File: rtl/cal_timeout_mon.sv
// Module: poll timeout monitor. Armed by the accepted start, it counts clock
// edges until done. When LIMIT edges pass without done, it raises a sticky
// timeout flag.
// Assumes: arm_i pulses at most once per reset; done_i is sticky.
module cal_timeout_mon #(
    parameter int LIMIT = 5000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic arm_i,
    input  logic done_i,
    output logic timeout_o
);

    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LIMIT - 1);

    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tmo_q;

    // Remember that a run has been started.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            armed_q <= 1'b0;
        end else if (arm_i) begin
            armed_q <= 1'b1;
        end
    end

    // Count waiting edges and raise the sticky timeout at the limit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            tmo_q <= 1'b0;
        end else if (armed_q && !done_i && !tmo_q) begin
            if (cnt_q == LAST_CNT) begin
                tmo_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign timeout_o = tmo_q;

    a_r8_timeout_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timeout_o |=> timeout_o)
        else $error("timeout flag dropped");

    a_r8_no_timeout_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(timeout_o) |-> $past(!done_i))
        else $error("timeout raised although done was present");

endmodule

// File: rtl/cal_copy_ctrl.sv
// Module: copy controller. It accepts one start per reset and applies the
// lifecycle gate. It steps the memory reads for the gating check, then copies
// each word to the target in ascending order, one handshake per register.
// Assumes: the memory holds values at 0..NUM_REGS-1 and the check word at
// NUM_REGS. It answers a held request with one mem_rvalid_i pulse.
module cal_copy_ctrl
    import cal_copy_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 16,
    parameter int IDX_W    = $clog2(NUM_REGS + 1),
    parameter int REG_AW   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              lc_mandatory_i,
    input  logic              copy_en_i,
    input  logic              chk_mode_i,
    output logic              mem_req_o,
    output logic [IDX_W-1:0]  mem_addr_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_rvalid_i,
    output logic              wr_valid_o,
    input  logic              wr_ready_i,
    output logic [REG_AW-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              init_done_o,
    output logic              start_ack_o,
    output logic              mode_o,
    output logic              fold_clr_o,
    output logic              fold_en_o,
    output logic              chk_load_o,
    input  logic              chk_pass_i
);

    localparam logic [IDX_W-1:0] CHK_IDX  = IDX_W'(NUM_REGS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

    seq_state_e        st_q;
    logic [IDX_W-1:0]  idx_q;
    logic              mode_q;
    logic [DATA_W-1:0] data_q;
    logic              run_ok;

    // Copy is allowed when mandatory by lifecycle or selected by input.
    assign run_ok = lc_mandatory_i | copy_en_i;

    // Sequence state, index, mode and copy data register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            mode_q <= 1'b0;
            data_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        mode_q <= chk_mode_i;
                        if (run_ok) begin
                            idx_q <= chk_mode_i ? '0 : CHK_IDX;
                            st_q  <= ST_VRD;
                        end else begin
                            st_q  <= ST_HALT;
                        end
                    end
                end
                ST_VRD: begin
                    if (mem_rvalid_i) begin
                        if (idx_q == CHK_IDX) begin
                            st_q <= ST_VCMP;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_VCMP: begin
                    if (chk_pass_i) begin
                        idx_q <= '0;
                        st_q  <= ST_CRD;
                    end else begin
                        st_q  <= ST_HALT;
                    end
                end
                ST_CRD: begin
                    if (mem_rvalid_i) begin
                        data_q <= mem_rdata_i;
                        st_q   <= ST_CWR;
                    end
                end
                ST_CWR: begin
                    if (wr_ready_i) begin
                        if (idx_q == LAST_IDX) begin
                            st_q <= ST_DONE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            st_q  <= ST_CRD;
                        end
                    end
                end
                ST_DONE: st_q <= ST_DONE;
                default: st_q <= ST_HALT;
            endcase
        end
    end

    // Drive memory, target and check-unit controls from the state.
    always_comb begin
        mem_req_o   = (st_q == ST_VRD) || (st_q == ST_CRD);
        mem_addr_o  = idx_q;
        wr_valid_o  = (st_q == ST_CWR);
        wr_addr_o   = idx_q[REG_AW-1:0];
        wr_data_o   = data_q;
        init_done_o = (st_q == ST_DONE);
        start_ack_o = (st_q == ST_IDLE) && start_i;
        fold_clr_o  = start_ack_o;
        fold_en_o   = (st_q == ST_VRD) && mem_rvalid_i && (idx_q != CHK_IDX);
        chk_load_o  = (st_q == ST_VRD) && mem_rvalid_i && (idx_q == CHK_IDX);
        mode_o      = mode_q;
    end

    // Checker state: handshakes seen so far, and whether a check has passed.
    logic [IDX_W-1:0] seen_q;
    logic             ok_q;
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seen_q <= '0;
            ok_q   <= 1'b0;
        end else begin
            if (wr_valid_o && wr_ready_i) seen_q <= seen_q + 1'b1;
            if ((st_q == ST_VCMP) && chk_pass_i) ok_q <= 1'b1;
        end
    end

    a_r1_ascending_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_valid_o && wr_ready_i) |-> (IDX_W'(wr_addr_o) == seen_q))
        else $error("write address out of sequence");

    a_r3_hold_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)))
        else $error("write request changed before ready");

    a_r3_mem_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)))
        else $error("memory request dropped before data");

    a_r4_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(init_done_o) |-> $past(wr_valid_o && wr_ready_i && (IDX_W'(wr_addr_o) == LAST_IDX)))
        else $error("done raised without final write");

    a_r4_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        init_done_o |=> init_done_o)
        else $error("done dropped");

    a_r5_r6_write_needs_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_valid_o |-> ok_q)
        else $error("write issued without a passing check");

endmodule

// File: rtl/cal_copy_seq.sv
// Module: top of the calibration copy sequencer. It ties the controller, the
// gating check unit and the poll timeout monitor together.
// Assumes: one clock domain; TIMEOUT_US converted with CLK_HZ.
module cal_copy_seq #(
    parameter int          NUM_REGS   = 8,
    parameter int          DATA_W     = 16,
    parameter logic [15:0] TAG        = 16'hC0DE,
    parameter int          CLK_HZ     = 50_000_000,
    parameter int          TIMEOUT_US = 100,
    parameter int          IDX_W      = $clog2(NUM_REGS + 1),
    parameter int          REG_AW     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              lc_mandatory_i,
    input  logic              copy_en_i,
    input  logic              chk_mode_i,
    output logic              mem_req_o,
    output logic [IDX_W-1:0]  mem_addr_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_rvalid_i,
    output logic              wr_valid_o,
    input  logic              wr_ready_i,
    output logic [REG_AW-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              init_done_o,
    output logic              timeout_o
);

    localparam int TIMEOUT_CYC = (CLK_HZ / 1_000_000) * TIMEOUT_US;

    logic start_ack;
    logic mode;
    logic fold_clr;
    logic fold_en;
    logic chk_load;
    logic chk_pass;

    cal_copy_ctrl #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W),
        .REG_AW   (REG_AW)
    ) u_ctrl (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .start_i        (start_i),
        .lc_mandatory_i (lc_mandatory_i),
        .copy_en_i      (copy_en_i),
        .chk_mode_i     (chk_mode_i),
        .mem_req_o      (mem_req_o),
        .mem_addr_o     (mem_addr_o),
        .mem_rdata_i    (mem_rdata_i),
        .mem_rvalid_i   (mem_rvalid_i),
        .wr_valid_o     (wr_valid_o),
        .wr_ready_i     (wr_ready_i),
        .wr_addr_o      (wr_addr_o),
        .wr_data_o      (wr_data_o),
        .init_done_o    (init_done_o),
        .start_ack_o    (start_ack),
        .mode_o         (mode),
        .fold_clr_o     (fold_clr),
        .fold_en_o      (fold_en),
        .chk_load_o     (chk_load),
        .chk_pass_i     (chk_pass)
    );

    cal_check_unit #(
        .DATA_W (DATA_W),
        .TAG    (TAG)
    ) u_check (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (fold_clr),
        .acc_en_i (fold_en),
        .load_i   (chk_load),
        .mode_i   (mode),
        .data_i   (mem_rdata_i),
        .pass_o   (chk_pass)
    );

    cal_timeout_mon #(
        .LIMIT (TIMEOUT_CYC)
    ) u_tmo (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .arm_i     (start_ack),
        .done_i    (init_done_o),
        .timeout_o (timeout_o)
    );

    // R10: all outputs low in the cycle after a reset edge.
    a_r10_reset_quiet: assert property (@(posedge clk_i)
        !$past(rst_ni) |-> (!mem_req_o && !wr_valid_o && !init_done_o && !timeout_o))
        else $error("outputs active after reset");

endmodule

// File: tb/tb_cal_copy_seq.sv
module tb_cal_copy_seq;

    localparam int N      = 8;
    localparam int DW     = 16;
    localparam int IW     = $clog2(N + 1);
    localparam int AW     = $clog2(N);
    localparam int LIMIT  = 5000;
    localparam int LAT    = 2;
    localparam logic [15:0] TAGV = 16'hC0DE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          lc_mand = 1'b0;
    logic          copy_en = 1'b0;
    logic          chk_mode = 1'b0;
    logic          mem_req;
    logic [IW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_rvalid = 1'b0;
    logic          wr_valid;
    logic          wr_ready = 1'b0;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          done;
    logic          tmo;

    cal_copy_seq dut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .start_i        (start),
        .lc_mandatory_i (lc_mand),
        .copy_en_i      (copy_en),
        .chk_mode_i     (chk_mode),
        .mem_req_o      (mem_req),
        .mem_addr_o     (mem_addr),
        .mem_rdata_i    (mem_rdata),
        .mem_rvalid_i   (mem_rvalid),
        .wr_valid_o     (wr_valid),
        .wr_ready_i     (wr_ready),
        .wr_addr_o      (wr_addr),
        .wr_data_o      (wr_data),
        .init_done_o    (done),
        .timeout_o      (tmo)
    );

    always #10 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [DW-1:0] mem [0:N];
    logic [DW-1:0] log_data [0:63];
    int            log_addr [0:63];
    int            wr_cnt, rd_cnt, lat_ctr, rdy_ctr;
    bit            stall, early_done;

    // Memory and target models; also logs every write handshake.
    always @(negedge clk) begin
        if (!rst_n) begin
            wr_cnt = 0; rd_cnt = 0; lat_ctr = 0; rdy_ctr = 0;
            early_done = 0; mem_rvalid = 0; wr_ready = 0;
        end else begin
            rdy_ctr++;
            wr_ready = stall ? ((rdy_ctr % 3) == 0) : 1'b1;
            if (wr_valid && wr_ready) begin
                if (wr_cnt < 64) begin
                    log_addr[wr_cnt] = int'(wr_addr);
                    log_data[wr_cnt] = wr_data;
                end
                wr_cnt++;
            end
            if (done && wr_cnt < N) early_done = 1;
            if (mem_rvalid) begin
                mem_rvalid = 0;
            end else if (mem_req) begin
                lat_ctr++;
                if (lat_ctr >= LAT) begin
                    mem_rvalid = 1;
                    mem_rdata  = mem[int'(mem_addr)];
                    lat_ctr    = 0;
                    rd_cnt++;
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] val(input int i, input int salt);
        return DW'(i * 16'h1F3B + 16'h0A5A + salt);
    endfunction

    // mode 0: tag, mode 1: digest; good=0 corrupts the check word.
    task automatic fill_mem(input bit dig, input bit good, input int salt);
        logic [DW-1:0] f = '0;
        for (int i = 0; i < N; i++) begin
            mem[i] = val(i, salt);
            f ^= mem[i];
        end
        mem[N] = dig ? f : TAGV;
        if (!good) mem[N] = mem[N] ^ 16'h0100;
    endtask

    task automatic do_reset();
        rst_n = 0; start = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
    endtask

    task automatic pulse_start(output int t0);
        @(negedge clk); start = 1;
        @(negedge clk); start = 0; #1;
        t0 = cyc;
    endtask

    task automatic wait_cyc(input int target);
        while (cyc < target) @(negedge clk);
        #1;
    endtask

    task automatic check_log(input string req, input int salt);
        check({req, " write count"}, wr_cnt, N);
        for (int i = 0; i < N; i++) begin
            check({req, " R1 addr order"}, log_addr[i], i);
            check({req, " R2 data"}, int'(log_data[i]), int'(val(i, salt)));
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R10 mem_req", int'(mem_req), 0);
        check("R10 wr_valid", int'(wr_valid), 0);
        check("R10 done", int'(done), 0);
        check("R10 timeout", int'(tmo), 0);
    endtask

    task automatic t_tag_pass();
        int t0;
        stall = 0; lc_mand = 1; copy_en = 0; chk_mode = 0;
        fill_mem(0, 1, 0);
        do_reset();
        pulse_start(t0);
        wait_cyc(t0 + 200);
        check("R4 R7 done after mandatory tag copy", int'(done), 1);
        check_log("R5 R7", 0);
        check("R5 tag mode reads only check word + N", rd_cnt, N + 1);
        wait_cyc(t0 + LIMIT + 20);
        check("R8 no timeout after done", int'(tmo), 0);
        check("R4 done sticky", int'(done), 1);
    endtask

    task automatic t_digest_stall();
        int t0;
        stall = 1; lc_mand = 0; copy_en = 1; chk_mode = 1;
        fill_mem(1, 1, 7);
        do_reset();
        pulse_start(t0);
        wait_cyc(t0 + 400);
        check("R6 done after digest copy", int'(done), 1);
        check_log("R3 R6", 7);
        check("R4 done not before last write", int'(early_done), 0);
        check("R6 digest reads", rd_cnt, 2 * N + 1);
    endtask

    task automatic t_fail(input bit dig, input string req);
        int t0;
        stall = 0; lc_mand = 1; copy_en = 1; chk_mode = dig;
        fill_mem(dig, 0, 3);
        do_reset();
        pulse_start(t0);
        wait_cyc(t0 + LIMIT - 1);
        check({req, " no writes on mismatch"}, wr_cnt, 0);
        check({req, " no done on mismatch"}, int'(done), 0);
        check("R8 timeout not yet", int'(tmo), 0);
        @(negedge clk); #1;
        check("R8 timeout at limit", int'(tmo), 1);
        wait_cyc(t0 + LIMIT + 10);
        check("R8 timeout sticky", int'(tmo), 1);
    endtask

    task automatic t_skip();
        int t0;
        stall = 0; lc_mand = 0; copy_en = 0; chk_mode = 0;
        fill_mem(0, 1, 0);
        do_reset();
        pulse_start(t0);
        wait_cyc(t0 + 300);
        check("R7 skip no reads", rd_cnt, 0);
        check("R7 skip no writes", wr_cnt, 0);
        check("R7 skip no done", int'(done), 0);
    endtask

    task automatic t_restart();
        int t0, tx;
        stall = 1; lc_mand = 1; copy_en = 1; chk_mode = 0;
        fill_mem(0, 1, 5);
        do_reset();
        pulse_start(t0);
        wait_cyc(t0 + 12);
        pulse_start(tx);
        wait_cyc(t0 + 400);
        check("R9 done after busy start", int'(done), 1);
        fill_mem(0, 1, 9);
        pulse_start(tx);
        wait_cyc(tx + 300);
        check_log("R9", 5);
        check("R9 no reads after end", rd_cnt, N + 1);
    endtask

    initial begin
        t_reset();
        t_tag_pass();
        t_digest_stall();
        t_fail(0, "R5");
        t_fail(1, "R6");
        t_skip();
        t_restart();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        tests++; fails++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule